// File: doc/BRIEF.md
# PHY Test-Port Write Sequencer

This block lets a host program internal registers of a display PHY through the PHY's serial test-control port. The port has three kinds of line: a test strobe clock, a test enable, and an 8-bit data bus. The PHY code and the PHY data share the 8-bit bus. The host issues one command that carries an 8-bit register code, a byte count and a hold count. The block then works through the strobe sequence one step at a time. Each step keeps its outputs fixed for a programmed number of system clocks, which gives the PHY its setup and hold margin.

The command runs in two phases. In the code phase the register code is latched into the PHY by an enable pulse, with a clock edge before the pulse and a clock edge inside it. In the data phase each byte is then clocked in while the enable stays low. Data bytes arrive through a valid/ready port into a small queue, and they can be loaded before the command or while it runs. If the next byte has not arrived yet, the sequencer waits with the strobe clock and the enable both low. The host sees busy for the whole run and a one-cycle done pulse when the run ends.

Top module: `phy_test_seq`

## Requirements
- R1: While reset is asserted and after it, tst_clk, tst_en and tst_din are 0, busy and done are 0, and byte_ready is 1 (the queue is empty).
- R2: A command (cmd_valid high) is taken only at a clock edge where busy is low. A cmd_valid that is high while busy has no effect on the outputs, and once done has pulsed busy stays low.
- R3: The code phase has five steps. Step 1 sets tst_clk=1 with tst_din unchanged. Step 2 sets tst_din=code. Step 3 sets tst_en=1. Step 4 sets tst_clk=0. Step 5 sets tst_en=0.
- R4: Each data byte has three steps, all with tst_en=0. Step 1 sets tst_clk=0 with tst_din unchanged. Step 2 sets tst_din=byte. Step 3 sets tst_clk=1. Bytes go out in the order they entered the queue, and only after the code phase.
- R5: Each step lasts exactly max(cmd_hold,1) clock cycles, so a hold of 0 acts as 1. The hold is sampled when the command is accepted.
- R6: The first step shows on the outputs in the cycle after the accepting edge, and busy is 1 from that cycle through the last step. In the cycle after the last step, busy is 0 and done is 1 for exactly one cycle. The port lines then keep their last values.
- R7: A byte count of 0 runs the code phase only, so the run has 5 steps.
- R8: If the queue is empty when step 1 of a byte ends, the sequencer stays in that step, with tst_clk=0, tst_en=0 and busy=1, until a byte arrives. It then moves to step 2 on the edge after the byte is queued.
- R9: The byte queue holds QDEPTH bytes. byte_ready is 0 when the queue is full, and a byte offered while byte_ready is 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request, taken only when idle |
| cmd_code | input | 8 | PHY register code |
| cmd_count | input | CNT_W | Number of data bytes to send |
| cmd_hold | input | HOLD_W | Cycles per step (0 acts as 1) |
| byte_valid | input | 1 | Data byte offered to the queue |
| byte_data | input | 8 | Data byte |
| byte_ready | output | 1 | Queue can take a byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| tst_clk | output | 1 | PHY test strobe clock |
| tst_en | output | 1 | PHY test enable |
| tst_din | output | 8 | PHY test data bus |

## Verification
The assertions assume that reset is held for at least one edge before any traffic. They also assume that data bytes are pushed only through the valid/ready handshake, so the queue count always reflects pushes and pops. The stimulus keeps cmd_count no larger than the number of bytes it supplies, either before the command or during a stall. A command therefore always finishes, and the stall check only sees the waiting step. Random commands keep the byte count within QDEPTH, so every byte can be loaded before the start. A separate case offers one byte too many to a full queue, to show that the extra byte is dropped.

// File: rtl/pts_pkg.sv
package pts_pkg;
  localparam int DIN_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CK_HI,
    ST_CODE,
    ST_EN_HI,
    ST_CK_LO,
    ST_EN_LO,
    ST_D_LOW,
    ST_D_PUT,
    ST_D_HIGH
  } pts_step_e;
endpackage

// File: rtl/pts_byteq.sv
module pts_byteq #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         pop,
  output logic         nonempty,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, take;
  logic [AW-1:0] wp_nx, rp_nx;

  assign in_ready = (cnt != CW'(DEPTH));
  assign nonempty = (cnt != '0);
  assign push     = in_valid && in_ready;
  assign take     = pop && nonempty;
  assign out_data = mem[rp];

  generate
    if (POW2) begin : g_wrap_nat
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
    end else begin : g_wrap_cmp
      assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp_nx;
      if (take) rp <= rp_nx;
      case ({push, take})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9
  q_fill_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && push && !take) |-> (cnt == $past(cnt) + 1'b1));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/pts_pacer.sv
module pts_pacer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [HOLD_W-1:0] load_val,
  output logic              expired
);
  logic [HOLD_W-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (!expired)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/pts_seq.sv
module pts_seq
  import pts_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [DIN_W-1:0]  cmd_code,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [HOLD_W-1:0] cmd_hold,
  input  logic              q_nonempty,
  input  logic [DIN_W-1:0]  q_data,
  output logic              q_pop,
  input  logic              step_done,
  output logic              pace_load,
  output logic [HOLD_W-1:0] pace_val,
  output logic              busy,
  output logic              done,
  output logic              tst_clk,
  output logic              tst_en,
  output logic [DIN_W-1:0]  tst_din
);
  pts_step_e         st, st_n;
  logic [DIN_W-1:0]  code_q;
  logic [CNT_W-1:0]  rem, rem_n;
  logic [HOLD_W-1:0] hold_q, hsel;
  logic              n_clk, n_en, fin, accept;
  logic [DIN_W-1:0]  n_din;

  assign accept   = (st == ST_IDLE) && cmd_valid;
  assign hsel     = accept ? cmd_hold : hold_q;
  assign pace_val = (hsel == '0) ? '0 : hsel - 1'b1;

  always_comb begin
    st_n      = st;
    rem_n     = rem;
    n_clk     = tst_clk;
    n_en      = tst_en;
    n_din     = tst_din;
    q_pop     = 1'b0;
    pace_load = 1'b0;
    fin       = 1'b0;
    if (st == ST_IDLE) begin
      if (cmd_valid) begin
        st_n      = ST_CK_HI;
        n_clk     = 1'b1;
        rem_n     = cmd_count;
        pace_load = 1'b1;
      end
    end else if (step_done) begin
      case (st)
        ST_CK_HI: begin st_n = ST_CODE;  n_din = code_q; pace_load = 1'b1; end
        ST_CODE:  begin st_n = ST_EN_HI; n_en = 1'b1;    pace_load = 1'b1; end
        ST_EN_HI: begin st_n = ST_CK_LO; n_clk = 1'b0;   pace_load = 1'b1; end
        ST_CK_LO: begin st_n = ST_EN_LO; n_en = 1'b0;    pace_load = 1'b1; end
        ST_EN_LO, ST_D_HIGH: begin
          if (rem == '0) begin
            st_n = ST_IDLE;
            fin  = 1'b1;
          end else begin
            st_n      = ST_D_LOW;
            n_clk     = 1'b0;
            pace_load = 1'b1;
          end
        end
        ST_D_LOW: begin
          if (q_nonempty) begin
            st_n      = ST_D_PUT;
            n_din     = q_data;
            q_pop     = 1'b1;
            pace_load = 1'b1;
          end
        end
        ST_D_PUT: begin
          st_n      = ST_D_HIGH;
          n_clk     = 1'b1;
          rem_n     = rem - 1'b1;
          pace_load = 1'b1;
        end
        default: begin st_n = ST_IDLE; fin = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      rem     <= '0;
      code_q  <= '0;
      hold_q  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      tst_clk <= 1'b0;
      tst_en  <= 1'b0;
      tst_din <= '0;
    end else begin
      st      <= st_n;
      rem     <= rem_n;
      tst_clk <= n_clk;
      tst_en  <= n_en;
      tst_din <= n_din;
      done    <= fin;
      if (accept) begin
        code_q <= cmd_code;
        hold_q <= cmd_hold;
        busy   <= 1'b1;
      end else if (fin) begin
        busy   <= 1'b0;
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(hold_q));

  // R5
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && !step_done) |=> ($stable(tst_clk) && $stable(tst_en) && $stable(tst_din)));

  // R8
  stall_safe_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_D_LOW && !q_nonempty) |=> (!tst_clk && !tst_en && busy));

  // R4
  data_en_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_D_LOW || st == ST_D_PUT || st == ST_D_HIGH) |-> !tst_en);

  // R3
  en_rise_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tst_en) |-> tst_clk);

  // R3
  en_fall_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tst_en) |-> !tst_clk);
endmodule

// File: rtl/phy_test_seq.sv
module phy_test_seq #(
  parameter int CNT_W  = 8,
  parameter int HOLD_W = 8,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [HOLD_W-1:0] cmd_hold,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              byte_ready,
  output logic              busy,
  output logic              done,
  output logic              tst_clk,
  output logic              tst_en,
  output logic [7:0]        tst_din
);
  logic              q_nonempty, q_pop, step_done, pace_load;
  logic [7:0]        q_data;
  logic [HOLD_W-1:0] pace_val;

  pts_byteq #(.W(8), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst(rst),
    .in_valid(byte_valid), .in_data(byte_data), .in_ready(byte_ready),
    .pop(q_pop), .nonempty(q_nonempty), .out_data(q_data)
  );

  pts_pacer #(.HOLD_W(HOLD_W)) u_pace (
    .clk(clk), .rst(rst),
    .load(pace_load), .load_val(pace_val), .expired(step_done)
  );

  pts_seq #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_count(cmd_count), .cmd_hold(cmd_hold),
    .q_nonempty(q_nonempty), .q_data(q_data), .q_pop(q_pop),
    .step_done(step_done), .pace_load(pace_load), .pace_val(pace_val),
    .busy(busy), .done(done),
    .tst_clk(tst_clk), .tst_en(tst_en), .tst_din(tst_din)
  );

  // R1
  reset_lines_chk: assert property (@(posedge clk)
    $past(rst) |-> (!tst_clk && !tst_en && tst_din == 8'h00 && !busy));
endmodule

// File: tb/sim_phy_test_seq.sv
module sim_phy_test_seq;
  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid;
  logic [7:0] cmd_code;
  logic [7:0] cmd_count;
  logic [7:0] cmd_hold;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       byte_ready, busy, done, tst_clk, tst_en;
  logic [7:0] tst_din;

  int n_run  = 0;
  int n_fail = 0;
  logic [7:0] last_din;
  logic [7:0] bq [4];

  always #2 clk = ~clk;

  phy_test_seq u0 (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_count(cmd_count), .cmd_hold(cmd_hold),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .busy(busy), .done(done), .tst_clk(tst_clk), .tst_en(tst_en), .tst_din(tst_din)
  );

  function automatic int eff_hold(input logic [7:0] h);
    return (h == 8'd0) ? 1 : int'(h);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge; samples H cycles, returns at the negedge after the step.
  task automatic step(input logic c, input logic e, input logic [7:0] d, input int h, input string req);
    for (int i = 0; i < h; i++) begin
      chk({tst_clk, tst_en, tst_din, busy, done} == {c, e, d, 1'b1, 1'b0}, req,
          {5'd0, tst_clk, tst_en, tst_din, busy, done}, {5'd0, c, e, d, 1'b1, 1'b0});
      @(negedge clk);
    end
  endtask

  task automatic code_steps(input logic [7:0] code, input int h);
    step(1'b1, 1'b0, last_din, h, "R3 ck_hi");
    step(1'b1, 1'b0, code, h, "R3 code");
    step(1'b1, 1'b1, code, h, "R3 en_hi");
    step(1'b0, 1'b1, code, h, "R3 ck_lo");
    step(1'b0, 1'b0, code, h, "R3 en_lo R5");
    last_din = code;
  endtask

  task automatic byte_steps(input logic [7:0] b, input int h);
    step(1'b0, 1'b0, last_din, h, "R4 d_low");
    step(1'b0, 1'b0, b, h, "R4 d_put");
    step(1'b1, 1'b0, b, h, "R4 d_high");
    last_din = b;
  endtask

  task automatic finish_chk;
    chk(done === 1'b1 && busy === 1'b0, "R6 done_pulse", {14'd0, done, busy}, 16'h0002);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R6 R2 idle_after", {14'd0, done, busy}, 16'h0000);
  endtask

  task automatic push_byte(input logic [7:0] d);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = d;
    @(posedge clk);
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic start_cmd(input logic [7:0] code, input logic [7:0] cnt, input logic [7:0] hold, input bit poke);
    @(negedge clk);
    cmd_code  = code;
    cmd_count = cnt;
    cmd_hold  = hold;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (poke) begin
      cmd_code = ~code;
      cmd_hold = hold + 8'd3;
    end else begin
      cmd_valid = 1'b0;
    end
  endtask

  // Bytes must already sit in bq and in the queue.
  task automatic run_cmd(input logic [7:0] code, input logic [7:0] cnt, input logic [7:0] hold, input bit poke);
    int h;
    h = eff_hold(hold);
    start_cmd(code, cnt, hold, poke);
    code_steps(code, h);
    for (int i = 0; i < int'(cnt); i++) byte_steps(bq[i], h);
    finish_chk();
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    int cnt;
    logic [7:0] code, hold;
    seed = 32'h5eed;
    void'($urandom(seed));
    rst = 1'b1; cmd_valid = 1'b0; cmd_code = '0; cmd_count = '0; cmd_hold = '0;
    byte_valid = 1'b0; byte_data = '0;
    last_din = 8'h00;
    repeat (3) @(negedge clk);
    chk({tst_clk, tst_en, tst_din, busy, done, byte_ready} == 13'h001, "R1 in_reset",
        {3'd0, tst_clk, tst_en, tst_din, busy, done, byte_ready}, 16'h0001);
    rst = 1'b0;
    @(negedge clk);
    chk({tst_clk, tst_en, tst_din, busy, done, byte_ready} == 13'h001, "R1 after_reset",
        {3'd0, tst_clk, tst_en, tst_din, busy, done, byte_ready}, 16'h0001);

    // R7: code phase only, hold 1
    run_cmd(8'hA5, 8'd0, 8'd1, 1'b0);
    // R5: hold 0 acts as 1, single byte
    bq[0] = 8'h3C; push_byte(bq[0]);
    run_cmd(8'h12, 8'd1, 8'd0, 1'b0);
    // R2: command poked while busy, hold 3, two bytes; R5 hold sampled at accept
    bq[0] = 8'h81; bq[1] = 8'h7E; push_byte(bq[0]); push_byte(bq[1]);
    run_cmd(8'h44, 8'd2, 8'd3, 1'b1);
    // same code twice with different bytes
    bq[0] = 8'h01; push_byte(bq[0]);
    run_cmd(8'h44, 8'd1, 8'd2, 1'b0);
    bq[0] = 8'hF0; push_byte(bq[0]);
    run_cmd(8'h44, 8'd1, 8'd2, 1'b0);

    // R9: fill queue, then offer one byte too many
    for (int i = 0; i < 4; i++) begin
      bq[i] = 8'h20 + 8'(i);
      push_byte(bq[i]);
    end
    chk(byte_ready == 1'b0, "R9 full_not_ready", {15'd0, byte_ready}, 16'h0000);
    push_byte(8'hEE);
    run_cmd(8'h5A, 8'd4, 8'd1, 1'b0);
    chk(byte_ready == 1'b1, "R9 ready_after_drain", {15'd0, byte_ready}, 16'h0001);

    // R8: queue empty (extra byte was dropped) -> stall in low step
    start_cmd(8'h66, 8'd1, 8'd2, 1'b0);
    code_steps(8'h66, 2);
    step(1'b0, 1'b0, last_din, 2, "R4 d_low");
    for (int i = 0; i < 6; i++) begin
      chk({tst_clk, tst_en, tst_din, busy} == {2'b00, last_din, 1'b1}, "R8 stall",
          {5'd0, tst_clk, tst_en, tst_din, busy, 1'b0}, {5'd0, 2'b00, last_din, 2'b10});
      @(negedge clk);
    end
    bq[0] = 8'hC3;
    push_byte(bq[0]);
    chk(tst_din == last_din && !tst_clk, "R8 still_low", {8'd0, tst_din}, {8'd0, last_din});
    @(negedge clk);
    step(1'b0, 1'b0, bq[0], 2, "R8 R4 d_put");
    step(1'b1, 1'b0, bq[0], 2, "R4 d_high");
    last_din = bq[0];
    finish_chk();

    // Random commands
    for (int t = 0; t < 20; t++) begin
      code = 8'($urandom);
      cnt  = int'($urandom % 5);
      hold = 8'($urandom % 4);
      for (int i = 0; i < cnt; i++) begin
        bq[i] = 8'($urandom);
        push_byte(bq[i]);
      end
      run_cmd(code, 8'(cnt), hold, (t % 3) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule